// File: doc/BRIEF.md
# Base-20 Console Formatter

This block turns one unsigned register value into the eight characters that show it as a base-20 number on a character console. A single start pulse captures the value. The block then breaks the value into eight radix-20 digits, one digit per cycle, and keeps them in a small buffer. It then sends the digits one at a time, most significant first, on a valid/ready character stream.

Each digit becomes a character code in the console's 400-entry code page. Values 0 to 9 map to the characters `0` to `9`, and values 10 to 19 map to the letters `A` to `J`. Leading zeros are always printed, so every request produces exactly eight characters. A one-cycle done pulse marks the acceptance of the last character, and `busy_o` covers the whole request.

Top module: `base20_console_fmt`

## Requirements
- R1: While reset is held, and right after it is released, `char_valid_o`, `busy_o` and `done_o` are all low.
- R2: Each accepted start produces exactly eight character handshakes, one for each base-20 digit. The digits go out from most significant to least significant, and leading zeros are included.
- R3: A digit whose value is 0 to 9 is sent as code 48 plus the digit value, which gives codes 48 to 57.
- R4: A digit whose value is 10 to 19 is sent as code 65 plus (digit value minus 10), which gives codes 65 to 74.
- R5: The value is taken as unsigned modulo 20^8. For an input at or above 20^8, only its low eight base-20 digits are printed.
- R6: The first character is offered (`char_valid_o` goes high) 9 clock cycles after the clock edge that accepts start. These are the eight digit-extraction cycles plus one.
- R7: While `char_valid_o` is high and `char_ready_i` is low, `char_valid_o` stays high and `char_code_o` holds its value on the next cycle.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The request in progress finishes with its own digits, and no further characters appear after its done pulse.
- R9: `busy_o` is high from the cycle after start is accepted until the last character is accepted. `done_o` is high for exactly one cycle, the cycle after the edge that accepts the last character, and `busy_o` is low in that cycle.
- R10: `value_i` is sampled only on the edge that accepts start. Changing it later has no effect on the characters of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; honoured only when idle |
| value_i | input | VAL_W (35) | Unsigned value to print |
| char_valid_o | output | 1 | A character code is offered |
| char_ready_i | input | 1 | Console accepts the offered character |
| char_code_o | output | CODE_W (9) | Code-page character code, 0 to 399 |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse after the last character is accepted |

## Verification
The test values are chosen so that a fault in one part of the digit path shows up as its own failure:
- All zeros checks that leading zeros are printed.
- The largest legal value gives all `J`s, which exercises the top letter code.
- A power of 20 puts a single `1` in the top place, which shows whether the output order is reversed.
- A hand-built value that mixes 0, 9, 10 and 19 in known places separates the numeric branch of the code map from the letter branch.
- A value above 20^8 checks the modulo wrap.

Each value is sent with the console always ready and again with ready held low on a regular pattern. The stalled runs show whether a code changes during backpressure. During one run, start is pulsed and `value_i` is changed while the block is busy; this shows whether the block restarts or samples the input again.

// File: rtl/b20_fmt_pkg.sv
package b20_fmt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_EMIT = 2'd2
  } fmt_state_e;

  localparam int unsigned NUMERAL_BASE = 48;  // code of '0'
  localparam int unsigned LETTER_BASE  = 65;  // code of 'A'
  localparam int unsigned DEC_LIMIT    = 10;
endpackage

// File: rtl/b20_div_step.sv
module b20_div_step #(
  parameter int unsigned VAL_W = 35,
  parameter int unsigned RADIX = 20,
  parameter int unsigned DIG_W = 5
) (
  input  logic [VAL_W-1:0] value_i,
  output logic [VAL_W-1:0] quot_o,
  output logic [DIG_W-1:0] rem_o
);
  logic [VAL_W-1:0] rem_full;

  always_comb begin
    quot_o   = value_i / VAL_W'(RADIX);
    rem_full = value_i % VAL_W'(RADIX);
    rem_o    = rem_full[DIG_W-1:0];
  end
endmodule

// File: rtl/b20_glyph_map.sv
module b20_glyph_map
  import b20_fmt_pkg::*;
#(
  parameter int unsigned DIG_W  = 5,
  parameter int unsigned CODE_W = 9
) (
  input  logic [DIG_W-1:0]  digit_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    if (digit_i < DIG_W'(DEC_LIMIT))
      code_o = CODE_W'(NUMERAL_BASE) + CODE_W'(digit_i);
    else
      code_o = CODE_W'(LETTER_BASE - DEC_LIMIT) + CODE_W'(digit_i);
  end
endmodule

// File: rtl/base20_console_fmt.sv
module base20_console_fmt
  import b20_fmt_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned RADIX      = 20,
  parameter int unsigned VAL_W      = 35,
  parameter int unsigned CODE_W     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              char_valid_o,
  input  logic              char_ready_i,
  output logic [CODE_W-1:0] char_code_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned DIG_W = $clog2(RADIX);
  localparam int unsigned IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DIGITS - 1);

  fmt_state_e       state_q;
  logic [VAL_W-1:0] work_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic [DIG_W-1:0] digit_q [NUM_DIGITS];

  logic [VAL_W-1:0] quot;
  logic [DIG_W-1:0] rem;
  logic [DIG_W-1:0] cur_digit;
  logic             accept_start;
  logic             char_fire;

  b20_div_step #(
    .VAL_W (VAL_W),
    .RADIX (RADIX),
    .DIG_W (DIG_W)
  ) i_div (
    .value_i (work_q),
    .quot_o  (quot),
    .rem_o   (rem)
  );

  assign accept_start = start_i && (state_q == ST_IDLE);
  assign char_fire    = (state_q == ST_EMIT) && char_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            work_q  <= value_i;
            idx_q   <= '0;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          work_q <= quot;
          if (idx_q == IDX_LAST) state_q <= ST_EMIT;  // idx stays at MSD
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_EMIT: begin
          if (char_fire) begin
            if (idx_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // digit buffer, LSD in slot 0
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        digit_q[g] <= '0;
      else if ((state_q == ST_CONV) && (idx_q == IDX_W'(g)))
        digit_q[g] <= rem;
    end
  end

  assign cur_digit = digit_q[idx_q];

  b20_glyph_map #(
    .DIG_W  (DIG_W),
    .CODE_W (CODE_W)
  ) i_map (
    .digit_i (cur_digit),
    .code_o  (char_code_o)
  );

  assign char_valid_o = (state_q == ST_EMIT);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
endmodule

// File: rtl/b20_fmt_checker.sv
module b20_fmt_checker #(
  parameter int unsigned NUM_DIGITS = 8,
  parameter int unsigned CODE_W     = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              char_valid_o,
  input logic              char_ready_i,
  input logic [CODE_W-1:0] char_code_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int unsigned CNT_W = $clog2(NUM_DIGITS + 1);

  logic [CNT_W-1:0] acc_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    acc_cnt <= '0;
    else if (start_i && !busy_o)    acc_cnt <= '0;
    else if (char_valid_o && char_ready_i) acc_cnt <= acc_cnt + 1'b1;
  end

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o && !char_ready_i |=> char_valid_o && $stable(char_code_o));

  // R3 and R4: only numeral or letter codes leave the block
  p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> ((char_code_o >= CODE_W'(48) && char_code_o <= CODE_W'(57)) ||
                      (char_code_o >= CODE_W'(65) && char_code_o <= CODE_W'(74))));

  p_eight_chars_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> acc_cnt == CNT_W'(NUM_DIGITS));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(char_valid_o && char_ready_i));

  p_valid_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> busy_o);

  p_no_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(char_valid_o && char_ready_i) |=> busy_o);
endmodule

bind base20_console_fmt b20_fmt_checker #(
  .NUM_DIGITS (NUM_DIGITS),
  .CODE_W     (CODE_W)
) i_b20_fmt_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .char_valid_o (char_valid_o),
  .char_ready_i (char_ready_i),
  .char_code_o  (char_code_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/test_base20_console_fmt.sv
`timescale 1ns/1ps
module test_base20_console_fmt;
  localparam int VAL_W  = 35;
  localparam int CODE_W = 9;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [VAL_W-1:0]  value_i = '0;
  logic              char_valid_o;
  logic              char_ready_i = 1'b0;
  logic [CODE_W-1:0] char_code_o;
  logic              busy_o;
  logic              done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  base20_console_fmt i_base20_console_fmt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .value_i      (value_i),
    .char_valid_o (char_valid_o),
    .char_ready_i (char_ready_i),
    .char_code_o  (char_code_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int code_of(input int d);
    return (d < 10) ? 48 + d : 65 + (d - 10);
  endfunction

  task automatic reset_check();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!char_valid_o && !busy_o && !done_o, "R1", "outputs in reset",
        {char_valid_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!char_valid_o && !busy_o && !done_o, "R1", "outputs after reset",
        {char_valid_o, busy_o, done_o}, 0);
  endtask

  // mode 0: always ready; mode m: ready once every m+1 cycles
  task automatic run_case(input logic [VAL_W-1:0] val, input int mode,
                          input bit inject, input string tag);
    int exp_d[8];
    longint v = longint'(val);
    int lat, n, cyc;
    bit stalled = 0;
    bit rdy;
    int held = 0;
    for (int i = 0; i < 8; i++) begin
      exp_d[i] = int'(v % 20);
      v = v / 20;
    end
    @(negedge clk_i);
    value_i = val;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = inject;
    value_i = ~val;  // R10: later input changes must not matter
    lat = 1;
    chk(busy_o, "R9", {tag, " busy after start"}, busy_o, 1);
    while (!char_valid_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
      if (lat >= 3) start_i = 1'b0;
    end
    chk(lat == 9, "R6", {tag, " first char latency"}, lat, 9);
    n = 0;
    cyc = 0;
    while (n < 8 && cyc < 200) begin
      rdy = (mode == 0) || ((cyc % (mode + 1)) == mode);
      if (stalled)
        chk(char_valid_o && int'(char_code_o) == held, "R7", {tag, " hold under stall"},
            char_code_o, held);
      char_ready_i = rdy;
      if (inject) start_i = (n < 6);  // R8: start while busy
      if (char_valid_o && rdy) begin
        if (exp_d[7-n] >= 10)
          chk(int'(char_code_o) == code_of(exp_d[7-n]), "R4", {tag, " letter digit (R2 order)"},
              char_code_o, code_of(exp_d[7-n]));
        else
          chk(int'(char_code_o) == code_of(exp_d[7-n]), "R3", {tag, " numeral digit (R2 order)"},
              char_code_o, code_of(exp_d[7-n]));
        n++;
        stalled = 0;
      end else if (char_valid_o) begin
        stalled = 1;
        held = int'(char_code_o);
      end
      @(negedge clk_i);
      cyc++;
    end
    char_ready_i = 1'b0;
    start_i = 1'b0;
    chk(n == 8, "R2", {tag, " characters accepted"}, n, 8);
    chk(done_o && !busy_o, "R9", {tag, " done after last char"}, {done_o, busy_o}, 2);
    @(negedge clk_i);
    chk(!done_o && !char_valid_o, "R9", {tag, " done is one cycle"}, {done_o, char_valid_o}, 0);
    if (inject) begin
      for (int k = 0; k < 4; k++) begin
        chk(!busy_o && !char_valid_o, "R8", {tag, " no restart from busy start"},
            {busy_o, char_valid_o}, 0);
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    automatic int mix[8] = '{19, 0, 10, 9, 15, 1, 18, 5};
    automatic longint mv = 0;
    for (int i = 0; i < 8; i++) mv = mv * 20 + longint'(mix[i]);

    reset_check();
    run_case(35'd0, 0, 0, "R2 zeros");
    run_case(35'd25599999999, 0, 0, "R4 all J");
    run_case(35'd1280000000, 1, 0, "R2 power of 20");
    run_case(VAL_W'(mv), 0, 0, "R3 mixed");
    run_case(VAL_W'(mv), 2, 0, "R7 mixed stalled");
    run_case(35'h7_FFFF_FFFF, 1, 0, "R5 wrap");
    run_case(35'd12345678, 2, 1, "R10 busy start");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule